// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and routes each one to either a fast-interrupt output or a normal-interrupt output. Software controls it through a 32-bit register interface. The interface provides a routing select, a set-only enable, a separate enable-clear, software-raised requests and status readback.

A table of programmable vector slots, 16 by default, maps slot positions to arbitrary source numbers. The slot position sets the priority. A read of the current-vector register searches the table and returns the handler address of the highest-priority normal request that is pending. If nothing matches, it returns a programmable default address. The returned value is held on a debug port and locked until software writes the current-vector register to acknowledge. After that write, the next read searches the table again.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, both interrupt outputs are low and a current-vector read (offset 0x030) returns zero.
- R2: The normal output is high when any bit of enable AND raw AND NOT select is set. The fast output is high when any bit of enable AND raw AND select is set. Select (offset 0x00C) bit n = 1 routes source n to fast. Normal status reads at 0x000 and fast status reads at 0x004.
- R3: A write to 0x010 sets the enable bits written as 1 and keeps the others. A write to 0x014 clears the enable bits written as 1. Reading 0x010 returns the enable word.
- R4: A write to 0x018 sets software-request bits. These bits are ORed into raw status (0x008). A write to 0x01C clears the written software bits.
- R5: Hardware line n is sampled each clock into raw bit n with one cycle of latency. Clearing a software bit does not clear a raw bit that the hardware line still drives.
- R6: Vector slot i has its address at 0x100+4i and its control at 0x200+4i. Control bit 5 enables the slot and bits 4:0 give the source number. Control bits above bit 5 read as zero.
- R7: A current-vector read returns the address of the lowest-numbered enabled slot whose source is pending as a normal request. Sources routed to fast never match.
- R8: When no normal request matches an enabled slot, a current-vector read returns the default address (0x034).
- R9: The value from a current-vector read appears on the debug port and stays locked. Further reads return it unchanged until an acknowledge.
- R10: A write of any value to 0x030 releases the lock, so the next read searches the table again. It does not clear hardware-driven raw bits and does not change the debug port.
- R11: Byte strobes select which bytes are written in the select, protection (0x020), default, slot address and slot control registers.
- R12: Read data is registered. It appears the cycle after the read strobe and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLines | input | 32 | Level-sensitive hardware request lines |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte strobes for write data |
| busRdata | output | 32 | Registered read data |
| normIrq | output | 1 | Normal interrupt request to the core |
| fastIrq | output | 1 | Fast interrupt request to the core |
| curVecDbg | output | 32 | Locked current-vector value, readable without side effects |

## Verification
The priority search is tested with one pending source that maps to a middle slot, then with two sources pending at once, where the lower slot must win. It is also tested with a pending source that no slot serves and with a source routed to fast. These cases separate a correct slot order from a reversed one, and a real default fallback from a stale match. Requests are raised both by hardware lines and by software writes. This shows that the raw status is an OR of the two, and that clearing software bits leaves a hardware level in place. A lock-then-acknowledge sequence changes the pending set between reads, which shows whether a read returns the locked value or a fresh search.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Low-byte offsets inside page 0
  localparam logic [7:0] OFF_IRQSTAT = 8'h00;
  localparam logic [7:0] OFF_FIQSTAT = 8'h04;
  localparam logic [7:0] OFF_RAW     = 8'h08;
  localparam logic [7:0] OFF_SEL     = 8'h0C;
  localparam logic [7:0] OFF_ENSET   = 8'h10;
  localparam logic [7:0] OFF_ENCLR   = 8'h14;
  localparam logic [7:0] OFF_SOFT    = 8'h18;
  localparam logic [7:0] OFF_SOFTCLR = 8'h1C;
  localparam logic [7:0] OFF_PROT    = 8'h20;
  localparam logic [7:0] OFF_VEC     = 8'h30;
  localparam logic [7:0] OFF_DEF     = 8'h34;

  // Pages (address bits above 7) holding the slot tables
  localparam int PAGE_SLOTADDR = 1;
  localparam int PAGE_SLOTCTL  = 2;

  typedef enum logic [3:0] {
    T_NONE, T_IRQSTAT, T_FIQSTAT, T_RAW, T_SEL, T_ENSET, T_ENCLR,
    T_SOFT, T_SOFTCLR, T_PROT, T_VEC, T_DEF, T_SADDR, T_SCTL
  } target_e;

  typedef struct packed {
    logic      selWr;
    logic      enSet;
    logic      enClr;
    logic      softSet;
    logic      softClr;
    logic      protWr;
    logic      vecAck;
    logic      vecRd;
    logic      defWr;
    logic      slotAddrWr;
    logic      slotCtlWr;
    logic      rdEn;
    logic [5:0] slotIdx;
    target_e   rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/vic_regctl.sv
module vic_regctl
  import vic_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output ctlStrobe_t        st
);

  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  logic [7:0]        offs;
  logic [5:0]        idx;
  logic              aligned;
  target_e           tgt;

  assign page    = busAddr[ADDR_W-1:8];
  assign offs    = busAddr[7:0];
  assign idx     = busAddr[7:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    tgt = T_NONE;
    if (aligned) begin
      if (page == '0) begin
        case (offs)
          OFF_IRQSTAT: tgt = T_IRQSTAT;
          OFF_FIQSTAT: tgt = T_FIQSTAT;
          OFF_RAW:     tgt = T_RAW;
          OFF_SEL:     tgt = T_SEL;
          OFF_ENSET:   tgt = T_ENSET;
          OFF_ENCLR:   tgt = T_ENCLR;
          OFF_SOFT:    tgt = T_SOFT;
          OFF_SOFTCLR: tgt = T_SOFTCLR;
          OFF_PROT:    tgt = T_PROT;
          OFF_VEC:     tgt = T_VEC;
          OFF_DEF:     tgt = T_DEF;
          default:     tgt = T_NONE;
        endcase
      end else if (page == PAGE_W'(PAGE_SLOTADDR) && int'(idx) < NUM_SLOTS) begin
        tgt = T_SADDR;
      end else if (page == PAGE_W'(PAGE_SLOTCTL) && int'(idx) < NUM_SLOTS) begin
        tgt = T_SCTL;
      end
    end
  end

  always_comb begin
    st            = '0;
    st.slotIdx    = idx;
    st.rdSel      = tgt;
    st.rdEn       = busRe && !busWe;
    st.selWr      = busWe && (tgt == T_SEL);
    st.enSet      = busWe && (tgt == T_ENSET);
    st.enClr      = busWe && (tgt == T_ENCLR);
    st.softSet    = busWe && (tgt == T_SOFT);
    st.softClr    = busWe && (tgt == T_SOFTCLR);
    st.protWr     = busWe && (tgt == T_PROT);
    st.vecAck     = busWe && (tgt == T_VEC);
    st.defWr      = busWe && (tgt == T_DEF);
    st.slotAddrWr = busWe && (tgt == T_SADDR);
    st.slotCtlWr  = busWe && (tgt == T_SCTL);
    // reading the current vector has side effects (lock capture)
    st.vecRd      = busRe && !busWe && (tgt == T_VEC);
  end

endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   srcLines,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W/8-1:0] busBe,
  input  ctlStrobe_t          st,
  output logic [DATA_W-1:0]   busRdata,
  output logic                normIrq,
  output logic                fastIrq,
  output logic [DATA_W-1:0]   curVecDbg
);

  localparam int SRC_BITS = $clog2(DATA_W);
  localparam int CTL_W    = SRC_BITS + 1;
  localparam int BYTES    = DATA_W / 8;

  logic [DATA_W-1:0] srcQ, selReg, enReg, softReg, protReg, defVec, heldVec;
  logic              locked;
  logic [DATA_W-1:0] slotAddr [NUM_SLOTS];
  logic [CTL_W-1:0]  slotCtl  [NUM_SLOTS];

  logic [DATA_W-1:0] wrMask, wrBits, rawStat, irqPend, fiqPend, vecSel, rdNext;

  function automatic logic [DATA_W-1:0] laneMask(input logic [BYTES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < BYTES; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  assign wrMask  = laneMask(busBe);
  assign wrBits  = busWdata & wrMask;
  assign rawStat = srcQ | softReg;
  assign irqPend = enReg & rawStat & ~selReg;
  assign fiqPend = enReg & rawStat & selReg;

  // Sampled lines, routing, enable, software requests, plain registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ    <= '0;
      selReg  <= '0;
      enReg   <= '0;
      softReg <= '0;
      protReg <= '0;
      defVec  <= '0;
    end else begin
      srcQ <= srcLines;
      if (st.selWr)   selReg  <= (selReg & ~wrMask) | wrBits;
      if (st.enSet)   enReg   <= enReg | wrBits;
      if (st.enClr)   enReg   <= enReg & ~wrBits;
      if (st.softSet) softReg <= softReg | wrBits;
      if (st.softClr) softReg <= softReg & ~wrBits;
      if (st.protWr)  protReg <= (protReg & ~wrMask) | wrBits;
      if (st.defWr)   defVec  <= (defVec & ~wrMask) | wrBits;
    end
  end

  // Vector slot tables
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAddr[i] <= '0;
        slotCtl[i]  <= '0;
      end else if (st.slotIdx == 6'(i)) begin
        if (st.slotAddrWr) slotAddr[i] <= (slotAddr[i] & ~wrMask) | wrBits;
        if (st.slotCtlWr)
          slotCtl[i] <= (slotCtl[i] & ~wrMask[CTL_W-1:0]) | wrBits[CTL_W-1:0];
      end
    end
  end

  // Priority search: the lowest-numbered matching slot wins
  always_comb begin
    vecSel = defVec;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slotCtl[i][SRC_BITS] && irqPend[slotCtl[i][SRC_BITS-1:0]])
        vecSel = slotAddr[i];
    end
  end

  // Lock: the first read captures, the acknowledge releases
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldVec <= '0;
      locked  <= 1'b0;
    end else if (st.vecAck) begin
      locked <= 1'b0;
    end else if (st.vecRd && !locked) begin
      heldVec <= vecSel;
      locked  <= 1'b1;
    end
  end

  always_comb begin
    rdNext = '0;
    case (st.rdSel)
      T_IRQSTAT: rdNext = irqPend;
      T_FIQSTAT: rdNext = fiqPend;
      T_RAW:     rdNext = rawStat;
      T_SEL:     rdNext = selReg;
      T_ENSET:   rdNext = enReg;
      T_SOFT:    rdNext = softReg;
      T_PROT:    rdNext = protReg;
      T_VEC:     rdNext = locked ? heldVec : vecSel;
      T_DEF:     rdNext = defVec;
      T_SADDR: begin
        for (int k = 0; k < NUM_SLOTS; k++)
          if (st.slotIdx == 6'(k)) rdNext = slotAddr[k];
      end
      T_SCTL: begin
        for (int k = 0; k < NUM_SLOTS; k++)
          if (st.slotIdx == 6'(k)) rdNext = DATA_W'(slotCtl[k]);
      end
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         busRdata <= '0;
    else if (st.rdEn)  busRdata <= rdNext;
  end

  assign normIrq   = |irqPend;
  assign fastIrq   = |fiqPend;
  assign curVecDbg = heldVec;

endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
  import vic_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   srcLines,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic                busRe,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W/8-1:0] busBe,
  output logic [DATA_W-1:0]   busRdata,
  output logic                normIrq,
  output logic                fastIrq,
  output logic [DATA_W-1:0]   curVecDbg
);

  ctlStrobe_t st;

  vic_regctl #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_ctl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .st(st)
  );

  vic_datapath #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .busWdata(busWdata),
    .busBe(busBe), .st(st), .busRdata(busRdata), .normIrq(normIrq),
    .fastIrq(fastIrq), .curVecDbg(curVecDbg)
  );

endmodule

// File: rtl/vic_irq_ctrl_chk.sv
module vic_irq_ctrl_chk
  import vic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic                busRe,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W/8-1:0] busBe,
  input logic [DATA_W-1:0]   busRdata,
  input logic                normIrq,
  input logic                fastIrq,
  input logic [DATA_W-1:0]   curVecDbg
);

  logic fullWr;
  assign fullWr = busWe && (busBe == '1) && (busWdata == '1);

  // R3
  en_clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullWr && busAddr == ADDR_W'(OFF_ENCLR) |=> !normIrq && !fastIrq);

  // R2
  sel_all_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullWr && busAddr == ADDR_W'(OFF_SEL) |=> !normIrq);

  // R9
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRe && !busWe && busAddr == ADDR_W'(OFF_VEC)) |=> $stable(curVecDbg));

  // R10
  ack_keeps_dbg_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && busAddr == ADDR_W'(OFF_VEC) |=> $stable(curVecDbg));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRe && !busWe) |=> $stable(busRdata));

endmodule

bind vic_irq_ctrl vic_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .busWdata(busWdata), .busBe(busBe), .busRdata(busRdata),
  .normIrq(normIrq), .fastIrq(fastIrq), .curVecDbg(curVecDbg)
);

// File: tb/sim_vic_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vic_irq_ctrl;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_IRQ = 3'd2,
                         OP_SRC = 3'd3, OP_DBG = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
  } vec_t;

  localparam int N = 64;
  // OP_IRQ exp: bit0 = normIrq, bit1 = fastIrq
  localparam vec_t TBL [N] = '{
    '{OP_WR, 4'd6, 12'h100, 32'h1000, 4'hF, 32'h0},     // R6 slot0 address
    '{OP_WR, 4'd6, 12'h104, 32'h1004, 4'hF, 32'h0},
    '{OP_WR, 4'd6, 12'h108, 32'h1008, 4'hF, 32'h0},
    '{OP_WR, 4'd6, 12'h200, 32'h23,   4'hF, 32'h0},     // slot0 -> src3
    '{OP_WR, 4'd6, 12'h204, 32'h25,   4'hF, 32'h0},     // slot1 -> src5
    '{OP_WR, 4'd6, 12'h208, 32'h27,   4'hF, 32'h0},     // slot2 -> src7
    '{OP_WR, 4'd8, 12'h034, 32'hDEF0, 4'hF, 32'h0},     // R8 default
    '{OP_WR, 4'd3, 12'h010, 32'hA8,   4'hF, 32'h0},
    '{OP_RD, 4'd3, 12'h010, 32'h0,    4'h0, 32'hA8},    // R3
    '{OP_WR, 4'd3, 12'h014, 32'h08,   4'hF, 32'h0},
    '{OP_RD, 4'd3, 12'h010, 32'h0,    4'h0, 32'hA0},
    '{OP_WR, 4'd3, 12'h010, 32'h08,   4'hF, 32'h0},
    '{OP_RD, 4'd3, 12'h010, 32'h0,    4'h0, 32'hA8},
    '{OP_SRC, 4'd5, 12'h0,  32'h20,   4'h0, 32'h0},
    '{OP_IRQ, 4'd2, 12'h0,  32'h0,    4'h0, 32'h1},     // R2 normal
    '{OP_RD, 4'd5, 12'h008, 32'h0,    4'h0, 32'h20},    // R5
    '{OP_RD, 4'd2, 12'h000, 32'h0,    4'h0, 32'h20},
    '{OP_RD, 4'd7, 12'h030, 32'h0,    4'h0, 32'h1004},  // R7 single source
    '{OP_WR, 4'd10, 12'h030, 32'h0,   4'hF, 32'h0},
    '{OP_SRC, 4'd7, 12'h0,  32'h28,   4'h0, 32'h0},
    '{OP_RD, 4'd7, 12'h030, 32'h0,    4'h0, 32'h1000},  // R7 slot0 beats slot1
    '{OP_SRC, 4'd9, 12'h0,  32'h20,   4'h0, 32'h0},
    '{OP_RD, 4'd9, 12'h030, 32'h0,    4'h0, 32'h1000},  // R9 locked
    '{OP_DBG, 4'd9, 12'h0,  32'h0,    4'h0, 32'h1000},
    '{OP_WR, 4'd10, 12'h030, 32'h77,  4'hF, 32'h0},
    '{OP_DBG, 4'd10, 12'h0, 32'h0,    4'h0, 32'h1000},  // R10 debug unchanged
    '{OP_RD, 4'd10, 12'h008, 32'h0,   4'h0, 32'h20},    // hw bit survives ack
    '{OP_RD, 4'd10, 12'h030, 32'h0,   4'h0, 32'h1004},  // re-evaluated
    '{OP_WR, 4'd10, 12'h030, 32'h0,   4'hF, 32'h0},
    '{OP_WR, 4'd2, 12'h00C, 32'h20,   4'hF, 32'h0},
    '{OP_IRQ, 4'd2, 12'h0,  32'h0,    4'h0, 32'h2},     // R2 fast
    '{OP_RD, 4'd2, 12'h004, 32'h0,    4'h0, 32'h20},
    '{OP_RD, 4'd8, 12'h030, 32'h0,    4'h0, 32'hDEF0},  // R8 fast never matches
    '{OP_WR, 4'd10, 12'h030, 32'h0,   4'hF, 32'h0},
    '{OP_SRC, 4'd2, 12'h0,  32'h0,    4'h0, 32'h0},
    '{OP_WR, 4'd2, 12'h00C, 32'h0,    4'hF, 32'h0},
    '{OP_IRQ, 4'd2, 12'h0,  32'h0,    4'h0, 32'h0},
    '{OP_WR, 4'd4, 12'h018, 32'h80,   4'hF, 32'h0},
    '{OP_RD, 4'd4, 12'h018, 32'h0,    4'h0, 32'h80},    // R4
    '{OP_RD, 4'd4, 12'h008, 32'h0,    4'h0, 32'h80},
    '{OP_IRQ, 4'd4, 12'h0,  32'h0,    4'h0, 32'h1},
    '{OP_RD, 4'd7, 12'h030, 32'h0,    4'h0, 32'h1008},
    '{OP_WR, 4'd10, 12'h030, 32'h0,   4'hF, 32'h0},
    '{OP_WR, 4'd4, 12'h01C, 32'h80,   4'hF, 32'h0},
    '{OP_RD, 4'd4, 12'h008, 32'h0,    4'h0, 32'h0},
    '{OP_IRQ, 4'd4, 12'h0,  32'h0,    4'h0, 32'h0},
    '{OP_SRC, 4'd5, 12'h0,  32'h80,   4'h0, 32'h0},
    '{OP_WR, 4'd5, 12'h018, 32'h80,   4'hF, 32'h0},
    '{OP_WR, 4'd5, 12'h01C, 32'h80,   4'hF, 32'h0},
    '{OP_RD, 4'd5, 12'h008, 32'h0,    4'h0, 32'h80},    // R5 hw level stays
    '{OP_RD, 4'd5, 12'h018, 32'h0,    4'h0, 32'h0},
    '{OP_SRC, 4'd5, 12'h0,  32'h0,    4'h0, 32'h0},
    '{OP_WR, 4'd8, 12'h010, 32'h2,    4'hF, 32'h0},
    '{OP_SRC, 4'd8, 12'h0,  32'h2,    4'h0, 32'h0},
    '{OP_RD, 4'd8, 12'h030, 32'h0,    4'h0, 32'hDEF0},  // R8 no slot serves src1
    '{OP_WR, 4'd10, 12'h030, 32'h0,   4'hF, 32'h0},
    '{OP_SRC, 4'd8, 12'h0,  32'h0,    4'h0, 32'h0},
    '{OP_WR, 4'd11, 12'h020, 32'hAABBCCDD, 4'h5, 32'h0},
    '{OP_RD, 4'd11, 12'h020, 32'h0,   4'h0, 32'h00BB00DD}, // R11
    '{OP_WR, 4'd11, 12'h034, 32'h11223344, 4'h2, 32'h0},
    '{OP_RD, 4'd11, 12'h034, 32'h0,   4'h0, 32'h000033F0},
    '{OP_RD, 4'd6, 12'h200, 32'h0,    4'h0, 32'h23},
    '{OP_WR, 4'd6, 12'h20C, 32'hFFFFFFE4, 4'hF, 32'h0},
    '{OP_RD, 4'd6, 12'h20C, 32'h0,    4'h0, 32'h24}     // R6 upper bits zero
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] srcLines = '0;
  logic [11:0] busAddr = '0;
  logic        busWe = 0, busRe = 0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busRdata, curVecDbg;
  logic        normIrq, fastIrq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vic_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .busAddr(busAddr),
    .busWe(busWe), .busRe(busRe), .busWdata(busWdata), .busBe(busBe),
    .busRdata(busRdata), .normIrq(normIrq), .fastIrq(fastIrq),
    .curVecDbg(curVecDbg)
  );

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWdata = d; busBe = be; busWe = 1;
    @(negedge clk);
    busWe = 0; busBe = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1;
    @(negedge clk);
    busRe = 0;
    d = busRdata;
  endtask

  task automatic setSrc(input logic [31:0] v);
    @(negedge clk);
    srcLines = v;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; srcLines = '0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    doReset();
    // R1 reset state
    rd(12'h010, d); chk(1, d, 32'h0);
    rd(12'h030, d); chk(1, d, 32'h0);
    chk(1, {30'd0, fastIrq, normIrq}, 32'h0);
    wr(12'h030, 32'h0, 4'hF);

    for (int i = 0; i < N; i++) begin
      case (TBL[i].op)
        OP_WR:  wr(TBL[i].addr, TBL[i].data, TBL[i].be);
        OP_RD:  begin rd(TBL[i].addr, d); chk(int'(TBL[i].req), d, TBL[i].exp); end
        OP_IRQ: chk(int'(TBL[i].req), {30'd0, fastIrq, normIrq}, TBL[i].exp);
        OP_SRC: setSrc(TBL[i].data);
        OP_DBG: chk(int'(TBL[i].req), curVecDbg, TBL[i].exp);
        default: ;
      endcase
    end

    // R12 registered read: old value before the edge, new value after
    rd(12'h00C, d); chk(12, d, 32'h0);
    @(negedge clk);
    busAddr = 12'h010; busRe = 1;
    #1 chk(12, busRdata, 32'h0);
    @(negedge clk);
    busRe = 0;
    chk(12, busRdata, 32'hAA);

    // R1 mid-run reset clears the tables and outputs
    setSrc(32'h80);
    doReset();
    rd(12'h010, d); chk(1, d, 32'h0);
    rd(12'h034, d); chk(1, d, 32'h0);
    rd(12'h100, d); chk(1, d, 32'h0);
    chk(1, {30'd0, fastIrq, normIrq}, 32'h0);
    chk(1, curVecDbg, 32'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule